// File: doc/BRIEF.md
# Iterative AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key with the Advanced Encryption Standard. It holds a single round of logic and sends the state back through that round once per clock until the block is finished. One datapath does both directions. A select input, sampled with the start pulse, chooses the direction. Round keys are derived on the fly from the loaded key. The S-box is computed as a GF(2^8) inverse followed by the affine map, with no lookup table.

To use the block, present the data, the key and the direction, then pulse the start input while the engine is idle. Encryption ends ten clocks after the start is accepted. Decryption first steps the key schedule forward ten times to reach the final round key. It then walks the schedule backwards while it runs the inverse rounds, so it ends twenty clocks after the start. A one-cycle done pulse marks a valid result. The result stays unchanged until the next accepted start.

Top module: `blk_cipher_iter`

## Requirements
- R1: After a synchronous reset, done_o is low and result_o is all zeros.
- R2: With decrypt_i low, result_o is the AES-128 ciphertext of data_i under key_i. Byte 0 of the state, which is the first byte of the standard byte order, is bits [127:120].
- R3: With decrypt_i high, result_o is the AES-128 plaintext of data_i under key_i, using the same byte order as R2.
- R4: In encryption, done_o rises exactly 10 clock edges after the edge that accepts start_i.
- R5: In decryption, done_o rises exactly 20 clock edges after the edge that accepts start_i.
- R6: done_o is high for exactly one cycle per operation.
- R7: While idle and with no start, result_o does not change.
- R8: start_i pulses during an operation are ignored. They do not change the result or the latency of the operation in progress.
- R9: For any key and data, decrypting the ciphertext returns the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled with start_i |
| data_i | input | 128 | Input block |
| key_i | input | 128 | Cipher key |
| result_o | output | 128 | Output block |
| done_o | output | 1 | One-cycle pulse when result_o becomes valid |

## Verification
Assertions check on every cycle that the done pulse lasts one cycle, that the round counter never passes the round count, that the done pulse appears only once the engine has returned to idle, and that the output holds while idle. Only the bench scenarios can show that the values are correct. These include the published known-answer vectors in both directions, the all-zero case, the exact encrypt and decrypt latencies, the immunity to extra start pulses, and random round trips through both directions.

// File: rtl/cipher_pkg.sv
package cipher_pkg;
    localparam int NUM_ROUNDS = 10;
    localparam int BLK_W      = 128;
    localparam int CNT_W      = $clog2(NUM_ROUNDS + 1);

    typedef logic [7:0]       byte_t;
    typedef logic [31:0]      word_t;
    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [1:0] {PH_IDLE, PH_KEYX, PH_RUN} phase_e;

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t r = 8'h00;
        byte_t p = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ p;
            p = xtime(p);
        end
        return r;
    endfunction

    // a^254 = a^-1 (and 0 -> 0)
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p = a;
        byte_t r = 8'h01;
        for (int i = 0; i < 7; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t aff_fwd(input byte_t b);
        byte_t y;
        for (int i = 0; i < 8; i++)
            y[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
        return y ^ 8'h63;
    endfunction

    function automatic byte_t aff_inv(input byte_t b);
        byte_t y;
        for (int i = 0; i < 8; i++)
            y[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8];
        return y ^ 8'h05;
    endfunction

    function automatic byte_t sbox(input byte_t a);
        return aff_fwd(gf_inv(a));
    endfunction

    function automatic byte_t inv_sbox(input byte_t a);
        return gf_inv(aff_inv(a));
    endfunction

    function automatic word_t sub_word(input word_t w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    function automatic blk_t sub_bytes(input blk_t s, input logic inv);
        blk_t o;
        for (int k = 0; k < 16; k++)
            o[8*k +: 8] = inv ? inv_sbox(s[8*k +: 8]) : sbox(s[8*k +: 8]);
        return o;
    endfunction

    // byte index k = 4*col + row; byte 0 is the top byte
    function automatic blk_t shift_rows(input blk_t s, input logic inv);
        blk_t o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                int src;
                src = inv ? (r + 4*((c - r + 4) % 4)) : (r + 4*((c + r) % 4));
                o[127-8*(r+4*c) -: 8] = s[127-8*src -: 8];
            end
        return o;
    endfunction

    function automatic word_t mix_col(input word_t w, input logic inv);
        byte_t a0, a1, a2, a3;
        a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
        if (!inv)
            return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
                    a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
                    a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
                    xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
        return {gf_mul(a0,8'h0e) ^ gf_mul(a1,8'h0b) ^ gf_mul(a2,8'h0d) ^ gf_mul(a3,8'h09),
                gf_mul(a0,8'h09) ^ gf_mul(a1,8'h0e) ^ gf_mul(a2,8'h0b) ^ gf_mul(a3,8'h0d),
                gf_mul(a0,8'h0d) ^ gf_mul(a1,8'h09) ^ gf_mul(a2,8'h0e) ^ gf_mul(a3,8'h0b),
                gf_mul(a0,8'h0b) ^ gf_mul(a1,8'h0d) ^ gf_mul(a2,8'h09) ^ gf_mul(a3,8'h0e)};
    endfunction

    function automatic byte_t rc_up(input byte_t rc);
        return xtime(rc);
    endfunction

    function automatic byte_t rc_down(input byte_t rc);
        return rc[0] ? (((rc ^ 8'h1b) >> 1) | 8'h80) : (rc >> 1);
    endfunction

    function automatic blk_t key_fwd(input blk_t k, input byte_t rc);
        word_t w0, w1, w2, w3, t;
        t  = sub_word({k[23:0], k[31:24]}) ^ {rc, 24'h0};
        w0 = k[127:96] ^ t;
        w1 = k[95:64]  ^ w0;
        w2 = k[63:32]  ^ w1;
        w3 = k[31:0]   ^ w2;
        return {w0, w1, w2, w3};
    endfunction

    function automatic blk_t key_inv(input blk_t k, input byte_t rc);
        word_t w0, w1, w2, w3;
        w3 = k[31:0]  ^ k[63:32];
        w2 = k[63:32] ^ k[95:64];
        w1 = k[95:64] ^ k[127:96];
        w0 = k[127:96] ^ sub_word({w3[23:0], w3[31:24]}) ^ {rc, 24'h0};
        return {w0, w1, w2, w3};
    endfunction
endpackage

// File: rtl/cipher_ctrl.sv
module cipher_ctrl
    import cipher_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             decrypt,
    output phase_e           phase,
    output logic             dec_mode,
    output logic             accept,
    output logic             last,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign accept = (phase == PH_IDLE) && start;
    assign last   = (cnt_q == CNT_W'(NUM_ROUNDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt_q    <= '0;
            dec_mode <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    cnt_q    <= CNT_W'(1);
                    dec_mode <= decrypt;
                    phase    <= decrypt ? PH_KEYX : PH_RUN;
                end
                PH_KEYX: begin
                    if (last) begin
                        cnt_q <= CNT_W'(1);
                        phase <= PH_RUN;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_RUN: begin
                    if (last) begin
                        cnt_q <= '0;
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_done_onecycle_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NUM_ROUNDS));
endmodule

// File: rtl/cipher_keysched.sv
module cipher_keysched
    import cipher_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  blk_t key_in,
    input  logic fwd_step,
    input  logic bwd_step,
    output blk_t key_next,
    output blk_t key_prev
);
    blk_t  key_q;
    byte_t rc_q;
    byte_t rc_prev;

    assign rc_prev  = rc_down(rc_q);
    assign key_next = key_fwd(key_q, rc_q);
    assign key_prev = key_inv(key_q, rc_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            rc_q  <= 8'h01;
        end else if (load) begin
            key_q <= key_in;
            rc_q  <= 8'h01;
        end else if (fwd_step) begin
            key_q <= key_next;
            rc_q  <= rc_up(rc_q);
        end else if (bwd_step) begin
            key_q <= key_prev;
            rc_q  <= rc_prev;
        end
    end

    assert_rc_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        rc_q != 8'h00);
endmodule

// File: rtl/cipher_round.sv
module cipher_round
    import cipher_pkg::*;
(
    input  blk_t state,
    input  blk_t rkey,
    input  logic inv,
    input  logic last,
    output blk_t nxt
);
    blk_t pre;
    blk_t mixed;

    // encrypt: shift(sub(s)); decrypt: sub^-1(shift^-1(s)) ^ k
    assign pre = inv ? (sub_bytes(shift_rows(state, 1'b1), 1'b1) ^ rkey)
                     : shift_rows(sub_bytes(state, 1'b0), 1'b0);

    for (genvar c = 0; c < 4; c++) begin : g_col
        assign mixed[127-32*c -: 32] = mix_col(pre[127-32*c -: 32], inv);
    end

    always_comb begin
        if (inv) nxt = last ? pre : mixed;
        else     nxt = (last ? pre : mixed) ^ rkey;
    end
endmodule

// File: rtl/blk_cipher_iter.sv
module blk_cipher_iter
    import cipher_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         decrypt_i,
    input  logic [127:0] data_i,
    input  logic [127:0] key_i,
    output logic [127:0] result_o,
    output logic         done_o
);
    phase_e phase;
    logic   dec_mode, accept, last;
    blk_t   state_q, key_next, key_prev, round_out, rkey;
    logic   fwd_step, bwd_step;

    cipher_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .decrypt(decrypt_i),
        .phase(phase), .dec_mode(dec_mode), .accept(accept),
        .last(last), .done(done_o)
    );

    assign fwd_step = (phase == PH_KEYX) || (phase == PH_RUN && !dec_mode);
    assign bwd_step = (phase == PH_RUN) && dec_mode;

    cipher_keysched u_keys (
        .clk(clk), .rst(rst), .load(accept), .key_in(key_i),
        .fwd_step(fwd_step), .bwd_step(bwd_step),
        .key_next(key_next), .key_prev(key_prev)
    );

    assign rkey = dec_mode ? key_prev : key_next;

    cipher_round u_round (
        .state(state_q), .rkey(rkey), .inv(dec_mode), .last(last), .nxt(round_out)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else if (accept)
            state_q <= decrypt_i ? data_i : (data_i ^ key_i);
        else if (phase == PH_KEYX && last)
            state_q <= state_q ^ key_next;
        else if (phase == PH_RUN)
            state_q <= round_out;
    end

    assign result_o = state_q;

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start_i) |=> $stable(result_o));
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (phase == PH_IDLE));
endmodule

// File: tb/blk_cipher_iter_bench.sv
module blk_cipher_iter_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         decrypt_i = 1'b0;
    logic [127:0] data_i = '0;
    logic [127:0] key_i = '0;
    logic [127:0] result_o;
    logic         done_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    blk_cipher_iter u_blk_cipher_iter (
        .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
        .data_i(data_i), .key_i(key_i), .result_o(result_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // runs one operation; returns result and the cycles until done
    task automatic run_op(input bit dec, input logic [127:0] d, input logic [127:0] k,
                          input bit poke_busy, output logic [127:0] res, output int lat);
        @(negedge clk);
        decrypt_i = dec; data_i = d; key_i = k; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
            if (poke_busy && lat == 5) begin
                start_i = 1'b1; decrypt_i = ~dec; data_i = ~d; key_i = ~k;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        res = result_o;
    endtask

    logic [127:0] r, r2, d, k, held;
    int lat;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done_o == 1'b0, "R1 done after reset", {127'h0, done_o}, 128'h0);
        chk(result_o == '0, "R1 result after reset", result_o, 128'h0);
        @(negedge clk); rst = 1'b0;

        // R2/R4: known answer, encrypt
        run_op(0, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 0, r, lat);
        chk(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 encrypt vector A", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk(lat == 10, "R4 encrypt latency", 128'(lat), 128'd10);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done drops after one cycle", {127'h0, done_o}, 128'h0);
        held = result_o;
        repeat (4) @(negedge clk);
        chk(result_o == held, "R7 result holds while idle", result_o, held);

        // R3/R5: known answer, decrypt
        run_op(1, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f, 0, r, lat);
        chk(r == 128'h00112233445566778899aabbccddeeff, "R3 decrypt vector A", r, 128'h00112233445566778899aabbccddeeff);
        chk(lat == 20, "R5 decrypt latency", 128'(lat), 128'd20);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done one cycle after decrypt", {127'h0, done_o}, 128'h0);

        run_op(0, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 0, r, lat);
        chk(r == 128'h3925841d02dc09fbdc118597196a0b32, "R2 encrypt vector B", r, 128'h3925841d02dc09fbdc118597196a0b32);
        run_op(1, 128'h3925841d02dc09fbdc118597196a0b32, 128'h2b7e151628aed2a6abf7158809cf4f3c, 0, r, lat);
        chk(r == 128'h3243f6a8885a308d313198a2e0370734, "R3 decrypt vector B", r, 128'h3243f6a8885a308d313198a2e0370734);

        // all-zero corner
        run_op(0, 128'h0, 128'h0, 0, r, lat);
        chk(r == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R2 encrypt all-zero", r, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        run_op(1, r, 128'h0, 0, r2, lat);
        chk(r2 == 128'h0, "R9 all-zero round trip", r2, 128'h0);

        // R8: start pulses while busy are ignored
        run_op(0, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 1, r, lat);
        chk(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R8 busy start ignored (encrypt)", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk(lat == 10, "R8 encrypt latency unchanged", 128'(lat), 128'd10);
        run_op(1, 128'h3925841d02dc09fbdc118597196a0b32, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1, r, lat);
        chk(r == 128'h3243f6a8885a308d313198a2e0370734, "R8 busy start ignored (decrypt)", r, 128'h3243f6a8885a308d313198a2e0370734);
        chk(lat == 20, "R8 decrypt latency unchanged", 128'(lat), 128'd20);

        // all-ones corner round trip
        run_op(0, '1, '1, 0, r, lat);
        run_op(1, r, '1, 0, r2, lat);
        chk(r2 == '1, "R9 all-ones round trip", r2, '1);

        // R9: random round trips
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 24; i++) begin
            d = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            run_op(0, d, k, 0, r, lat);
            chk(r != d, "R2 ciphertext differs from data", r, d);
            run_op(1, r, k, 0, r2, lat);
            chk(r2 == d, "R9 random round trip", r2, d);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule